// File: doc/BRIEF.md
# Serial-to-Parallel Word Recoverer

This block takes a framed serial bit stream, one bit per cycle on which a bit-tick enable is high, and turns it back into 12-bit parallel words. Each word on the line starts with a high start bit. Twelve data bits follow, least significant first, then a low end marker. On an over-clocked link every third word also carries two trailing low bits, which gives a 14, 14, 16 bit-time cadence. The block finds word boundaries and checks each end marker. After two good frames in a row it declares lock and from then on delivers every good word on a registered parallel output.

A regenerated word clock rises at each accepted start bit while locked, so each of its periods equals the spacing between start bits: 14 bit times, or 16 for a padded word. A direction input gates the parallel output enable. Outside receive direction the words keep their last value and the receive logic is held cleared. A power-down input resets everything and releases the outputs to high impedance through the enable.

Top module: `ser_word_rx`

## Requirements
- R1: A frame is a high start bit, then 12 data bits with bit 0 first, then a low end marker. The serial input is sampled only in cycles where `bit_en` is high, and the recovered word appears on `pdata`.
- R2: After a reset, after a framing error, and after a direction change, a high bit is taken as a start bit only if the bit just before it was low. A run of high bits starts no frame and raises no framing error.
- R3: `locked` rises at the end of the second good frame in a row. The first of these two frames is not delivered. The second one and every later good frame are loaded into `pdata`.
- R4: A high end marker pulses `frame_err`, clears `locked`, discards the word and leaves `pdata` unchanged. Two further good frames are needed before a word is delivered again.
- R5: Low bits after an end marker are skipped until the next start bit, so 16-bit padded words and the 14/14/16 cadence are received with the padding discarded.
- R6: While locked, `wclk` rises once for each accepted start bit, so the number of bit ticks between its rising edges equals the bit length of the word that started at the earlier edge (14 or 16).
- R7: `wclk` stays high for 7 bit ticks, counting the start bit, and then stays low until the next start bit.
- R8: While `rx_dir` is low, `pdata_oe` is low (one cycle later), `pdata` holds its last value, `locked` and `wclk` are low, and incoming frames have no effect. After `rx_dir` returns high, lock must be reacquired before `pdata` changes.
- R9: While `rst` or `pd` is high, `pdata` clears to zero and `pdata_oe`, `locked`, `wclk` and `frame_err` go low, one cycle after the input rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pd | input | 1 | Power-down: resets all receive logic |
| rx_dir | input | 1 | High selects receive direction |
| bit_en | input | 1 | Bit-tick enable from the serial clock |
| sin | input | 1 | Serial data bit |
| pdata | output | 12 | Recovered parallel word |
| pdata_oe | output | 1 | Output enable for the parallel pads |
| wclk | output | 1 | Regenerated word clock |
| locked | output | 1 | Word alignment acquired |
| frame_err | output | 1 | One-cycle pulse on a bad end marker |

## Verification
On every cycle the assertions check three things. `pdata` is stable unless a word is loaded, and power-down clears the outputs. A framing error never leaves lock set, and lock only rises after a good prior frame. The word clock only rises after a start bit accepted while locked, and the enable drops whenever `rx_dir` is low. The bench scenarios are needed for the rest. They show the start-to-start word clock periods across the 14/14/16 cadence and the seven-tick high phase. They show that the first frame of a lock pair is withheld, that runs of high bits are ignored, and that lock must be reacquired after an error or a direction change.

// File: rtl/swr_pkg.sv
package swr_pkg;
  typedef enum logic [1:0] {
    ST_WAIT = 2'd0,
    ST_DATA = 2'd1,
    ST_STOP = 2'd2
  } rx_state_t;
endpackage

// File: rtl/swr_deframer.sv
module swr_deframer
  import swr_pkg::*;
#(
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              clr,
  input  logic              bit_en,
  input  logic              sin,
  output logic              start_acc,
  output logic              word_ok,
  output logic              frame_err,
  output logic              locked,
  output logic [DATA_W-1:0] word
);
  localparam int CW = $clog2(DATA_W);

  rx_state_t st;
  logic          prev_low;
  logic          got_one;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (clr) begin
      st        <= ST_WAIT;
      prev_low  <= 1'b0;
      got_one   <= 1'b0;
      cnt       <= '0;
      locked    <= 1'b0;
      word      <= '0;
      start_acc <= 1'b0;
      word_ok   <= 1'b0;
      frame_err <= 1'b0;
    end else begin
      start_acc <= 1'b0;
      word_ok   <= 1'b0;
      frame_err <= 1'b0;
      if (bit_en) begin
        case (st)
          ST_WAIT: begin
            prev_low <= ~sin;
            if (sin && prev_low) begin
              st        <= ST_DATA;
              cnt       <= '0;
              start_acc <= 1'b1;
            end
          end
          ST_DATA: begin
            word <= {sin, word[DATA_W-1:1]};
            if (cnt == CW'(DATA_W - 1)) st <= ST_STOP;
            else cnt <= cnt + 1'b1;
          end
          ST_STOP: begin
            st <= ST_WAIT;
            if (!sin) begin
              prev_low <= 1'b1;
              got_one  <= 1'b1;
              if (got_one) begin
                locked  <= 1'b1;
                word_ok <= 1'b1;
              end
            end else begin
              frame_err <= 1'b1;
              locked    <= 1'b0;
              got_one   <= 1'b0;
              prev_low  <= 1'b0;
            end
          end
          default: st <= ST_WAIT;
        endcase
      end
    end
  end

  // R4: a framing error always leaves the receiver unlocked
  a_r4_err_unlocks: assert property (@(posedge clk) disable iff (clr)
    frame_err |-> !locked);
  // R3: lock only rises after an earlier good frame was recorded
  a_r3_lock_needs_pair: assert property (@(posedge clk) disable iff (clr)
    $rose(locked) |-> $past(got_one));
  // R4: a word is never delivered in the same cycle as a framing error
  a_r4_no_word_on_err: assert property (@(posedge clk) disable iff (clr)
    !(word_ok && frame_err));
endmodule

// File: rtl/swr_wordclk.sv
module swr_wordclk #(
  parameter int HALF = 7
) (
  input  logic clk,
  input  logic clr,
  input  logic bit_en,
  input  logic start,
  input  logic locked,
  output logic wclk
);
  localparam int HW = $clog2(HALF + 1);

  logic [HW-1:0] hcnt;

  always_ff @(posedge clk) begin
    if (clr) begin
      wclk <= 1'b0;
      hcnt <= '0;
    end else if (start && locked) begin
      wclk <= 1'b1;
      hcnt <= bit_en ? HW'(HALF - 2) : HW'(HALF - 1);
    end else if (bit_en && wclk) begin
      if (hcnt == '0) wclk <= 1'b0;
      else hcnt <= hcnt - 1'b1;
    end
  end

  // R6: the word clock rises only on a start bit accepted while locked
  a_r6_rise_on_start: assert property (@(posedge clk) disable iff (clr)
    $rose(wclk) |-> $past(start && locked));
endmodule

// File: rtl/swr_outreg.sv
module swr_outreg #(
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pd,
  input  logic              rx_dir,
  input  logic              load,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] pdata,
  output logic              pdata_oe
);
  logic clr;
  assign clr = rst | pd;

  always_ff @(posedge clk) begin
    if (clr) begin
      pdata    <= '0;
      pdata_oe <= 1'b0;
    end else begin
      pdata_oe <= rx_dir;
      if (load && rx_dir) pdata <= din;
    end
  end

  // R8: outputs hold unless a word is loaded
  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    (!load && !clr) |=> $stable(pdata));
  // R8: enable follows receive direction
  a_r8_oe_off: assert property (@(posedge clk) disable iff (rst)
    !rx_dir |=> !pdata_oe);
  // R9: power-down clears the word and releases the pads
  a_r9_pd_clear: assert property (@(posedge clk) disable iff (rst)
    pd |=> (pdata == '0 && !pdata_oe));
endmodule

// File: rtl/ser_word_rx.sv
module ser_word_rx #(
  parameter int DATA_W = 12,
  parameter int HALF   = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pd,
  input  logic              rx_dir,
  input  logic              bit_en,
  input  logic              sin,
  output logic [DATA_W-1:0] pdata,
  output logic              pdata_oe,
  output logic              wclk,
  output logic              locked,
  output logic              frame_err
);
  logic              rx_clr;
  logic              start_acc;
  logic              word_ok;
  logic [DATA_W-1:0] word;

  assign rx_clr = rst | pd | ~rx_dir;

  swr_deframer #(.DATA_W(DATA_W)) u_deframer (
    .clk       (clk),
    .clr       (rx_clr),
    .bit_en    (bit_en),
    .sin       (sin),
    .start_acc (start_acc),
    .word_ok   (word_ok),
    .frame_err (frame_err),
    .locked    (locked),
    .word      (word)
  );

  swr_wordclk #(.HALF(HALF)) u_wordclk (
    .clk    (clk),
    .clr    (rx_clr),
    .bit_en (bit_en),
    .start  (start_acc),
    .locked (locked),
    .wclk   (wclk)
  );

  swr_outreg #(.DATA_W(DATA_W)) u_outreg (
    .clk      (clk),
    .rst      (rst),
    .pd       (pd),
    .rx_dir   (rx_dir),
    .load     (word_ok),
    .din      (word),
    .pdata    (pdata),
    .pdata_oe (pdata_oe)
  );
endmodule

// File: tb/ser_word_rx_test.sv
module ser_word_rx_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [12:0] VEC [6] = '{13'h0A5C, 13'h03F1, 13'h1800,
                                      13'h0001, 13'h0FFE, 13'h15A3};

  logic        clk = 1'b0;
  logic        rst, pd, rx_dir, bit_en, sin;
  logic [11:0] pdata;
  logic        pdata_oe, wclk, locked, frame_err;

  int total = 0, fails = 0;
  int ticks = 0, last_rise = -1, period = 0, hi_run = 0, hi_last = 0;
  logic prev_w = 1'b0, err_seen = 1'b0, done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ser_word_rx uut (
    .clk(clk), .rst(rst), .pd(pd), .rx_dir(rx_dir), .bit_en(bit_en), .sin(sin),
    .pdata(pdata), .pdata_oe(pdata_oe), .wclk(wclk), .locked(locked),
    .frame_err(frame_err)
  );

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk);
    sin = b; bit_en = 1'b1;
    @(negedge clk);
    bit_en = 1'b0;
    if (frame_err) err_seen = 1'b1;
    @(negedge clk);
    if (wclk && !prev_w) begin
      if (last_rise >= 0) period = ticks - last_rise;
      last_rise = ticks;
      hi_run = 1;
    end else if (wclk) hi_run++;
    else if (prev_w) hi_last = hi_run;
    prev_w = wclk;
    ticks++;
  endtask

  task automatic send_frame(input logic [11:0] d, input logic long16, input logic endb);
    send_bit(1'b1);
    for (int k = 0; k < 12; k++) send_bit(d[k]);
    send_bit(endb);
    if (long16) begin send_bit(1'b0); send_bit(1'b0); end
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", total - fails, total);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; total++;
      $display("FAIL watchdog: actual hung expected done");
      summary();
      $finish;
    end
  end

  initial begin
    rst = 1'b1; pd = 1'b0; rx_dir = 1'b1; bit_en = 1'b0; sin = 1'b0;
    repeat (3) @(negedge clk);
    chk(pdata == 12'h0 && !locked && !wclk && !pdata_oe, "R9 reset", pdata, 0);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    chk(pdata_oe == 1'b1, "R8 oe on", pdata_oe, 1);

    // R2: run of high bits must not start a frame
    for (int k = 0; k < 20; k++) send_bit(1'b1);
    chk(!err_seen && !locked, "R2 ones ignored", err_seen, 0);

    // R3: lock pair
    send_bit(1'b0);
    send_frame(12'h123, 1'b0, 1'b0);
    chk(pdata == 12'h000 && !locked, "R3 first withheld", pdata, 12'h000);
    send_frame(12'h456, 1'b0, 1'b0);
    chk(pdata == 12'h456, "R3 second delivered", pdata, 12'h456);
    chk(locked == 1'b1, "R3 locked", locked, 1);

    // R1 R5 R6 R7: cadence table
    for (int i = 0; i < 6; i++) begin
      send_frame(VEC[i][11:0], VEC[i][12], 1'b0);
      chk(pdata == VEC[i][11:0], "R1 R5 word", pdata, VEC[i][11:0]);
      if (i > 0)
        chk(period == (VEC[i-1][12] ? 16 : 14), "R6 period", period, VEC[i-1][12] ? 16 : 14);
      chk(hi_last == 7, "R7 high time", hi_last, 7);
    end

    // R4: framing error
    err_seen = 1'b0;
    send_frame(12'h777, 1'b0, 1'b1);
    chk(err_seen == 1'b1, "R4 err pulse", err_seen, 1);
    chk(!locked, "R4 unlock", locked, 0);
    chk(pdata == 12'h5A3, "R4 discard", pdata, 12'h5A3);
    send_bit(1'b0);
    send_frame(12'h0F0, 1'b0, 1'b0);
    chk(pdata == 12'h5A3 && !locked, "R4 relock first", pdata, 12'h5A3);
    send_frame(12'h0F1, 1'b0, 1'b0);
    chk(pdata == 12'h0F1, "R4 relock second", pdata, 12'h0F1);

    // R8: direction
    rx_dir = 1'b0;
    repeat (2) @(negedge clk);
    chk(!pdata_oe, "R8 oe off", pdata_oe, 0);
    send_bit(1'b0);
    send_frame(12'hABC, 1'b0, 1'b0);
    send_frame(12'hABD, 1'b0, 1'b0);
    chk(pdata == 12'h0F1, "R8 hold", pdata, 12'h0F1);
    chk(!locked && !wclk, "R8 idle", locked, 0);
    rx_dir = 1'b1;
    send_bit(1'b0);
    send_frame(12'h321, 1'b0, 1'b0);
    chk(pdata == 12'h0F1, "R8 relock needed", pdata, 12'h0F1);
    send_frame(12'h322, 1'b0, 1'b0);
    chk(pdata == 12'h322 && pdata_oe, "R8 resume", pdata, 12'h322);

    // R9: power-down mid word
    send_bit(1'b1);
    chk(wclk == 1'b1, "R7 wclk high at start", wclk, 1);
    pd = 1'b1;
    repeat (2) @(negedge clk);
    chk(pdata == 12'h0 && !pdata_oe && !locked && !wclk, "R9 power-down", pdata, 0);
    pd = 1'b0;

    done = 1'b1;
    summary();
    $finish;
  end
endmodule